// File: doc/BRIEF.md
# FP8 to FP32 Widening Decoder

This block takes one 8-bit floating-point code per transfer and turns it into an IEEE single-precision word. Three flags come with the word: not-a-number, infinity and zero. A 2-bit format selector picks one of four 8-bit layouts. Two of them have a 4-bit exponent and a 3-bit mantissa, and two have a 5-bit exponent and a 2-bit mantissa. Each layout comes in a standard flavour, which keeps negative zero and the special encodings. It also comes in a compact flavour, which has no negative zero and no infinity, uses one more step of exponent bias, and keeps a single NaN code. A clip input applies to the standard 5-bit-exponent layout. When it is set, that layout's infinities come out as the largest finite magnitude instead.

Input and output are valid/ready streams. The format selector and the clip bit are sampled together with the code, so they must be held steady for as long as `in_valid` is high. With the default `REG_OUT = 1`, one register stage sits between the two streams. That stage accepts a new code whenever it is empty or its content is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, it holds the word and the flags unchanged and drops `in_ready`. With `REG_OUT = 0`, the path is purely combinational and the handshake passes straight through.

Top module: `fp8_to_fp32_decoder`

## Requirements
- R1: While reset is asserted, and after it is released before any input is accepted, `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_word` and the three flags hold their values. A transfer offered during the stall is accepted in the first cycle in which `out_ready` is high again.
- R3: Format codes are as follows: 0 is standard 4-bit-exponent, 1 is standard 5-bit-exponent, 2 is compact 4-bit-exponent and 3 is compact 5-bit-exponent. For a normal code, the result exponent is the field value minus the layout bias plus 127. The bias is 7, 15, 8 and 16 respectively. The mantissa is left-aligned in the 23-bit fraction with zero fill, and the sign is copied to bit 31.
- R4: A code with a zero exponent field and a non-zero mantissa is normalised: its leading one becomes implicit, and the exponent is lowered by the shift distance.
- R5: Code 0x00 gives 0x00000000 in every format. In the standard formats, code 0x80 gives 0x80000000. Both raise only the zero flag.
- R6: In the compact formats, 0x80 is the only NaN, and no code yields an infinity or a negative zero.
- R7: In the standard 4-bit-exponent format, magnitude 0x7F is NaN, and 0x7E gives 448 (0x43E00000) with its sign.
- R8: In the standard 5-bit-exponent format with clip low, an all-ones exponent with zero mantissa gives 0x7F800000 or 0xFF800000 and raises the infinity flag. An all-ones exponent with a non-zero mantissa is NaN.
- R9: With clip high, those two infinity codes give 0x47600000 or 0xC7600000 instead, with no flag raised.
- R10: Every NaN result is the word 0x7F800001 with only the NaN flag raised, and at most one flag is ever high.
- R11: With `REG_OUT = 1`, an accepted code appears on the output one clock later, with its flags in the same cycle. `out_valid` falls after the output is taken when no new code was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Decoder can take a code this cycle |
| in_code | input | 8 | FP8 code: sign, exponent, mantissa |
| in_fmt | input | 2 | Format selector (encoding in R3) |
| in_clip | input | 1 | Saturate standard 5-bit-exponent infinities |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | IEEE single-precision result |
| out_nan | output | 1 | Result is NaN |
| out_inf | output | 1 | Result is an infinity |
| out_zero | output | 1 | Result is a signed zero |

## Verification
The stall properties assume that a stalled consumer keeps `out_ready` low only while a result is pending. They also assume that the format and clip inputs stay steady while a code is offered. The directed tasks change `in_fmt` and `in_clip` only together with `in_code`, and only at a falling edge. The sweeps cover all 256 codes in every format, including the clip variant, and compare them against an arithmetic model that rebuilds each value from its integer significand and power of two. Separate stall and back-to-back streams check the hold and latency rules.

// File: rtl/fp8dec_pkg.sv
package fp8dec_pkg;
  localparam int CODE_W     = 8;
  localparam int SIG_W      = 3;   // widest mantissa among the layouts
  localparam int EXPF_W     = 5;   // widest exponent field
  localparam int F32_W      = 32;
  localparam int F32_EXP_W  = 8;
  localparam int F32_FRAC_W = 23;
  localparam int F32_BIAS   = 127;
  localparam int SH_W       = $clog2(SIG_W + 1);

  localparam logic [F32_W-1:0] NAN_WORD  = 32'h7F80_0001;
  localparam logic [F32_W-2:0] INF_MAG   = 31'h7F80_0000;
  localparam logic [F32_W-2:0] CLIP_MAG  = 31'h4760_0000;

  typedef enum logic [1:0] {
    FMT_E4_STD = 2'd0,
    FMT_E5_STD = 2'd1,
    FMT_E4_CMP = 2'd2,
    FMT_E5_CMP = 2'd3
  } fp8_fmt_e;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fp8_cls_e;

  typedef struct packed {
    logic nan;
    logic inf;
    logic zero;
  } fp8_flags_t;

  typedef struct packed {
    logic [F32_W-1:0] word;
    fp8_flags_t       flags;
  } fp8_res_t;
endpackage

// File: rtl/fp8dec_unpack.sv
module fp8dec_unpack
  import fp8dec_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  input  fp8_fmt_e           fmt,
  output logic               sign,
  output logic [EXPF_W-1:0]  exp_field,
  output logic [SIG_W-1:0]   frac3,
  output logic [EXPF_W-1:0]  bias,
  output fp8_cls_e           cls
);
  logic wide;
  logic compact;
  logic [CODE_W-2:0] mag;

  assign wide    = fmt[0];
  assign compact = fmt[1];
  assign sign    = code[CODE_W-1];
  assign mag     = code[CODE_W-2:0];

  always_comb begin
    if (wide) begin
      exp_field = code[6:2];
      frac3     = {code[1:0], 1'b0};
      bias      = EXPF_W'(15) + EXPF_W'(compact);
    end else begin
      exp_field = {1'b0, code[6:3]};
      frac3     = code[2:0];
      bias      = EXPF_W'(7) + EXPF_W'(compact);
    end
  end

  always_comb begin
    if (mag == '0) begin
      cls = (compact && sign) ? CLS_NAN : CLS_ZERO;
    end else if (!compact && !wide && (mag == 7'h7F)) begin
      cls = CLS_NAN;
    end else if (!compact && wide && (exp_field == 5'h1F)) begin
      cls = (frac3 == '0) ? CLS_INF : CLS_NAN;
    end else if (exp_field == '0) begin
      cls = CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fp8dec_normalize.sv
module fp8dec_normalize
  import fp8dec_pkg::*;
(
  input  logic [EXPF_W-1:0]     exp_field,
  input  logic [SIG_W-1:0]      frac3,
  input  logic [EXPF_W-1:0]     bias,
  output logic [F32_EXP_W-1:0]  exp8,
  output logic [F32_FRAC_W-1:0] frac23
);
  localparam int PAD_W = F32_FRAC_W - SIG_W;

  logic [SH_W-1:0]  sh;
  logic [SIG_W-1:0] aligned;
  logic             is_sub;

  assign is_sub = (exp_field == '0);

  // distance that moves the leading one just past the top of the field
  always_comb begin
    sh = SH_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (frac3[i]) sh = SH_W'(SIG_W - i);
    end
  end

  assign aligned = frac3 << sh;

  always_comb begin
    if (is_sub) begin
      exp8   = F32_EXP_W'(F32_BIAS + 1) - F32_EXP_W'(bias) - F32_EXP_W'(sh);
      frac23 = {aligned, {PAD_W{1'b0}}};
    end else begin
      exp8   = F32_EXP_W'(F32_BIAS) + F32_EXP_W'(exp_field) - F32_EXP_W'(bias);
      frac23 = {frac3, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fp8dec_pack.sv
module fp8dec_pack
  import fp8dec_pkg::*;
(
  input  logic                  sign,
  input  fp8_cls_e              cls,
  input  logic [F32_EXP_W-1:0]  exp8,
  input  logic [F32_FRAC_W-1:0] frac23,
  input  logic                  clip,
  output fp8_res_t              res
);
  always_comb begin
    res = '0;
    unique case (cls)
      CLS_ZERO: begin
        res.word       = {sign, {(F32_W-1){1'b0}}};
        res.flags.zero = 1'b1;
      end
      CLS_NAN: begin
        res.word      = NAN_WORD;
        res.flags.nan = 1'b1;
      end
      CLS_INF: begin
        if (clip) begin
          res.word = {sign, CLIP_MAG};
        end else begin
          res.word      = {sign, INF_MAG};
          res.flags.inf = 1'b1;
        end
      end
      default: res.word = {sign, exp8, frac23};
    endcase
  end
endmodule

// File: rtl/fp8dec_stage.sv
module fp8dec_stage
  import fp8dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  fp8_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output fp8_res_t out_res
);
  generate
    if (REG_OUT) begin : g_reg
      logic     vld_q;
      fp8_res_t res_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     res_q <= '0;
        else if (in_valid && in_ready)  res_q <= in_res;
      end

      assign out_valid = vld_q;
      assign out_res   = res_q;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_res   = in_res;
    end
  endgenerate
endmodule

// File: rtl/fp8_to_fp32_decoder.sv
module fp8_to_fp32_decoder
  import fp8dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_code,
  input  logic [1:0]  in_fmt,
  input  logic        in_clip,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word,
  output logic        out_nan,
  output logic        out_inf,
  output logic        out_zero
);
  logic                  sign;
  logic [EXPF_W-1:0]     exp_field;
  logic [SIG_W-1:0]      frac3;
  logic [EXPF_W-1:0]     bias;
  fp8_cls_e              cls;
  logic [F32_EXP_W-1:0]  exp8;
  logic [F32_FRAC_W-1:0] frac23;
  fp8_res_t              comb_res;
  fp8_res_t              stage_res;

  fp8dec_unpack u_unpack (
    .code      (in_code),
    .fmt       (fp8_fmt_e'(in_fmt)),
    .sign      (sign),
    .exp_field (exp_field),
    .frac3     (frac3),
    .bias      (bias),
    .cls       (cls)
  );

  fp8dec_normalize u_norm (
    .exp_field (exp_field),
    .frac3     (frac3),
    .bias      (bias),
    .exp8      (exp8),
    .frac23    (frac23)
  );

  fp8dec_pack u_pack (
    .sign   (sign),
    .cls    (cls),
    .exp8   (exp8),
    .frac23 (frac23),
    .clip   (in_clip),
    .res    (comb_res)
  );

  fp8dec_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (stage_res)
  );

  assign out_word = stage_res.word;
  assign out_nan  = stage_res.flags.nan;
  assign out_inf  = stage_res.flags.inf;
  assign out_zero = stage_res.flags.zero;
endmodule

// File: rtl/fp8dec_checker.sv
module fp8dec_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_nan,
  input logic        out_inf,
  input logic        out_zero
);
  assert_flags_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_nan, out_inf, out_zero}));

  assert_nan_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nan) |-> (out_word == 32'h7F80_0001));

  assert_inf_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inf) |-> (out_word[30:0] == 31'h7F80_0000));

  assert_zero_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_word[30:0] == 31'h0));

  assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  generate
    if (REG_OUT) begin : g_reg_chk
      assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
          $stable({out_nan, out_inf, out_zero})));

      assert_accept_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    end else begin : g_comb_chk
      assert_pass_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> out_valid);
    end
  endgenerate
endmodule

bind fp8_to_fp32_decoder fp8dec_checker #(.REG_OUT(REG_OUT)) u_fp8dec_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_nan   (out_nan),
  .out_inf   (out_inf),
  .out_zero  (out_zero)
);

// File: tb/tb_fp8_to_fp32_decoder.sv
`timescale 1ns/1ps
module tb_fp8_to_fp32_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_code = '0;
  logic [1:0]  in_fmt = '0;
  logic        in_clip = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_nan, out_inf, out_zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  fp8_to_fp32_decoder #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_fmt(in_fmt), .in_clip(in_clip),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_nan(out_nan), .out_inf(out_inf), .out_zero(out_zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [34:0] act, input logic [34:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // arithmetic reference: value = significand * 2^power, then renormalised
  function automatic logic [34:0] model(input logic [7:0] c, input logic [1:0] fmt,
                                         input logic clip, output string tag);
    int wide, cmp, we, wm, bias, e, m, sig, pw, p, ex;
    logic s;
    logic [22:0] fr;
    wide = fmt[0]; cmp = fmt[1];
    we = wide ? 5 : 4; wm = wide ? 2 : 3;
    bias = (1 << (we - 1)) - 1 + cmp;
    s = c[7];
    e = int'(c[6:0]) >> wm;
    m = int'(c[6:0]) & ((1 << wm) - 1);
    if (c[6:0] == 0) begin
      if (cmp && s) begin tag = "R6"; return {32'h7F800001, 3'b100}; end
      tag = "R5"; return {s, 31'h0, 3'b001};
    end
    if (!cmp && !wide && c[6:0] == 7'h7F) begin tag = "R7"; return {32'h7F800001, 3'b100}; end
    if (!cmp && wide && e == 31) begin
      if (m != 0) begin tag = "R8"; return {32'h7F800001, 3'b100}; end
      if (clip) begin tag = "R9"; return {s, 31'h47600000, 3'b000}; end
      tag = "R8"; return {s, 31'h7F800000, 3'b010};
    end
    sig = (e == 0) ? m : ((1 << wm) | m);
    pw  = ((e == 0) ? 1 : e) - bias - wm;
    p = 0;
    for (int k = 0; k < 8; k++) if ((sig >> k) & 1) p = k;
    ex = pw + p + 127;
    fr = 23'((sig << (23 - p)) & 32'h007FFFFF);
    tag = (e == 0) ? "R4" : ((!cmp && !wide && c[6:0] == 7'h7E) ? "R7" : "R3");
    return {s, ex[7:0], fr, 3'b000};
  endfunction

  function automatic logic [34:0] observed();
    return {out_word, out_nan, out_inf, out_zero};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "during reset", {33'h0, out_valid, in_ready}, 35'h1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "after release", {33'h0, out_valid, in_ready}, 35'h1);
  endtask

  task automatic t_sweep(input logic [1:0] fmt, input logic clip);
    for (int c = 0; c < 256; c++) begin
      logic [34:0] expv;
      string tag;
      @(negedge clk);
      in_valid = 1'b1; in_code = c[7:0]; in_fmt = fmt; in_clip = clip; out_ready = 1'b1;
      @(negedge clk);
      expv = model(c[7:0], fmt, clip, tag);
      check(out_valid && observed() == expv, tag,
            $sformatf("fmt %0d clip %0d code %02h", fmt, clip, c), observed(), expv);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_nan_word();
    logic [7:0] codes [4] = '{8'h7F, 8'h7D, 8'h80, 8'hFF};
    logic [1:0] fmts  [4] = '{2'd0, 2'd1, 2'd2, 2'd0};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_code = codes[k]; in_fmt = fmts[k]; in_clip = 1'b0;
      @(negedge clk);
      check(out_valid && observed() == {32'h7F800001, 3'b100}, "R10", "NaN word",
            observed(), {32'h7F800001, 3'b100});
    end
    in_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_code = 8'h38; in_fmt = 2'd0; in_clip = 1'b0;
    @(negedge clk);
    check(out_valid && !in_ready, "R2", "stall drops in_ready",
          {33'h0, out_valid, in_ready}, 35'h2);
    in_code = 8'h40;
    repeat (3) @(negedge clk);
    check(out_valid && observed() == {32'h3F800000, 3'b000}, "R2", "held during stall",
          observed(), {32'h3F800000, 3'b000});
    out_ready = 1'b1;
    #1;
    check(in_ready, "R2", "ready returns", {34'h0, in_ready}, 35'h1);
    @(negedge clk);
    check(out_valid && observed() == {32'h40000000, 3'b000}, "R2", "stalled input taken",
          observed(), {32'h40000000, 3'b000});
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R11", "valid falls when idle", {34'h0, out_valid}, 35'h0);
  endtask

  task automatic t_stream();
    logic [7:0]  codes [4] = '{8'h80, 8'h7C, 8'h00, 8'h01};
    logic [1:0]  fmts  [4] = '{2'd3, 2'd1, 2'd0, 2'd0};
    logic [34:0] expv  [4] = '{{32'h7F800001, 3'b100}, {32'h7F800000, 3'b010},
                              {32'h00000000, 3'b001}, {32'h3B000000, 3'b000}};
    @(negedge clk);
    out_ready = 1'b1; in_clip = 1'b0;
    in_valid = 1'b1; in_code = codes[0]; in_fmt = fmts[0];
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && observed() == expv[k], "R11",
            $sformatf("back-to-back item %0d", k), observed(), expv[k]);
      if (k < 3) begin in_code = codes[k+1]; in_fmt = fmts[k+1]; end
      else in_valid = 1'b0;
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
          $finish;
        end
      end
    join_none
    t_reset();
    t_sweep(2'd0, 1'b0);
    t_sweep(2'd1, 1'b0);
    t_sweep(2'd1, 1'b1);
    t_sweep(2'd2, 1'b0);
    t_sweep(2'd3, 1'b0);
    t_nan_word();
    t_backpressure();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule